// File: doc/BRIEF.md
# Global-History Correlating Direction Predictor

This block predicts whether a conditional branch will be taken. A shift register holds the outcomes of the most recent resolved branches, with taken stored as 1 and not taken as 0. That history is merged with bits of the branch address to select one 2-bit saturating counter in a table. The counter's upper bit is the prediction. A parameter picks how the history and the address are merged. One option XORs them across the whole index. The other places a few history bits above a run of address bits. With zero history bits in that second option, the block becomes a table indexed by the address alone.

Fetch presents a lookup address and, in the same cycle, receives the predicted direction and the current history value. It keeps that history with the branch. When the branch resolves, the pipeline returns the address, the outcome and the saved history through the update port. The saved history, not the live one, selects the counter that is trained. The live history then shifts in the outcome. Target prediction and repair of speculative history are not part of this block.

Top module: `ghist_predictor`

## Requirements
- R1: After reset every counter holds 01, so every lookup predicts not taken (0), and the history output is all zeros.
- R2: The prediction is the upper bit of the selected counter: 10 and 11 give taken (1); 00 and 01 give not taken (0).
- R3: An update with outcome taken raises the selected counter by one, saturating at 11. An update with outcome not taken lowers it by one, saturating at 00.
- R4: From a strong state (11 or 00), a single opposite outcome does not change the prediction; a second consecutive one does.
- R5: Each update shifts the history left by one and places the outcome in bit 0. Without an update the history holds its value.
- R6: In XOR mode (the default) the counter index is PC[11:2] XOR history[9:0].
- R7: In concatenation mode with 2 history bits the index is {history[1:0], PC[9:2]}.
- R8: An update changes only the counter that is indexed by the update PC and the history supplied with the update; every other counter keeps its value.
- R9: The lookup result is combinational from the table and history. An update becomes visible to lookups from the rising clock edge that accepts it onward. A lookup of the same counter in the cycle of its update sees the old value.
- R10: PC bits 1:0 have no effect on the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | HIST_W | Current global history, kept by fetch for the later update |
| up_valid | input | 1 | Update request for one resolved branch |
| up_pc | input | PC_W | Address of the resolved branch |
| up_hist | input | HIST_W | History value captured when that branch was predicted |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
Both outputs are combinational from state. `lk_taken` and `lk_hist` settle within the cycle in which `lk_pc` is applied. An update reaches the table and the history at the next rising edge. The bench therefore applies all inputs at the falling edge and samples the outputs 1 ns later. It advances its own counter table and history only after the following rising edge. This sampling point makes the same-cycle read of an updating counter return the old value, which is the case R9 describes. Two instances run side by side, one in each index mode, and each is compared against a reference model that computes its index in its own way.

// File: rtl/gpred_pkg.sv
package gpred_pkg;

  typedef enum logic {
    IDX_XOR    = 1'b0,
    IDX_CONCAT = 1'b1
  } idx_mode_e;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;
  localparam ctr_t CTR_MAX   = 2'b11;
  localparam ctr_t CTR_MIN   = 2'b00;

  // saturating step of one counter
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction

  // direction implied by a counter
  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/gpred_hist_reg.sv
module gpred_hist_reg #(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;

  generate
    if (HIST_W > 1) begin : g_wide
      always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], bit_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= bit_in;
      end
    end
  endgenerate

  assign hist = hist_q;

endmodule

// File: rtl/gpred_index.sv
module gpred_index #(
  parameter int                   HIST_W = 10,
  parameter int                   IDX_W  = 10,
  parameter int                   SEL_W  = 2,
  parameter gpred_pkg::idx_mode_e MODE   = gpred_pkg::IDX_XOR
) (
  input  logic [IDX_W-1:0]  pc_bits,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);

  localparam int FOLD_W = (HIST_W < IDX_W) ? HIST_W : IDX_W;
  localparam int ADDR_W = IDX_W - SEL_W;

  // history widened or trimmed to the index width
  function automatic logic [IDX_W-1:0] fold_hist(input logic [HIST_W-1:0] h);
    logic [IDX_W-1:0] f;
    f = '0;
    for (int i = 0; i < FOLD_W; i++) f[i] = h[i];
    return f;
  endfunction

  generate
    if (MODE == gpred_pkg::IDX_XOR) begin : g_xor
      assign idx = pc_bits ^ fold_hist(hist);
    end else if (SEL_W == 0) begin : g_addr_only
      assign idx = pc_bits;
    end else begin : g_concat
      assign idx = {hist[SEL_W-1:0], pc_bits[ADDR_W-1:0]};
    end
  endgenerate

endmodule

// File: rtl/gpred_pht.sv
module gpred_pht #(
  parameter int IDX_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      rd_idx,
  output gpred_pkg::ctr_t       rd_ctr,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic                  wr_taken,
  output gpred_pkg::ctr_t       wr_cur,
  output gpred_pkg::ctr_t       wr_next
);

  localparam int DEPTH = 1 << IDX_W;

  gpred_pkg::ctr_t tbl [DEPTH];

  assign rd_ctr  = tbl[rd_idx];
  assign wr_cur  = tbl[wr_idx];
  assign wr_next = gpred_pkg::ctr_step(wr_cur, wr_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= gpred_pkg::CTR_RESET;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_next;
    end
  end

endmodule

// File: rtl/ghist_predictor.sv
module ghist_predictor #(
  parameter int                   PC_W   = 32,
  parameter int                   HIST_W = 10,
  parameter int                   IDX_W  = 10,
  parameter int                   SEL_W  = 2,
  parameter gpred_pkg::idx_mode_e MODE   = gpred_pkg::IDX_XOR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [HIST_W-1:0] up_hist,
  input  logic              up_taken
);

  localparam int PC_LO = 2;
  localparam int PC_HI = PC_LO + IDX_W - 1;

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  gpred_pkg::ctr_t  lk_ctr;
  gpred_pkg::ctr_t  upd_cur;
  gpred_pkg::ctr_t  upd_next;
  logic             hist_shift;

  assign hist_shift = up_valid;

  gpred_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (hist_shift),
    .bit_in   (up_taken),
    .hist     (lk_hist)
  );

  gpred_index #(.HIST_W(HIST_W), .IDX_W(IDX_W), .SEL_W(SEL_W), .MODE(MODE)) u_lk_index (
    .pc_bits (lk_pc[PC_HI:PC_LO]),
    .hist    (lk_hist),
    .idx     (lk_idx)
  );

  gpred_index #(.HIST_W(HIST_W), .IDX_W(IDX_W), .SEL_W(SEL_W), .MODE(MODE)) u_up_index (
    .pc_bits (up_pc[PC_HI:PC_LO]),
    .hist    (up_hist),
    .idx     (up_idx)
  );

  gpred_pht #(.IDX_W(IDX_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_idx),
    .rd_ctr   (lk_ctr),
    .wr_en    (up_valid),
    .wr_idx   (up_idx),
    .wr_taken (up_taken),
    .wr_cur   (upd_cur),
    .wr_next  (upd_next)
  );

  assign lk_taken = gpred_pkg::ctr_dir(lk_ctr);

endmodule

// File: rtl/ghist_predictor_chk.sv
module ghist_predictor_chk #(
  parameter int HIST_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_taken,
  input logic [HIST_W-1:0] lk_hist,
  input logic [1:0]        upd_cur,
  input logic [1:0]        upd_next
);

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> lk_hist == {$past(lk_hist[HIST_W-2:0]), $past(up_taken)});

  // R5
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(lk_hist));

  // R3
  ctr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken) |-> (upd_next >= upd_cur) && (upd_next != 2'b00));

  // R3
  ctr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken) |-> (upd_next <= upd_cur) && (upd_next != 2'b11));

  // R4
  ctr_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> $countones(upd_next ^ upd_cur) <= 2 &&
                 ((upd_next - upd_cur == 2'd1) || (upd_cur - upd_next == 2'd1) ||
                  (upd_next == upd_cur)));

endmodule

bind ghist_predictor ghist_predictor_chk #(.HIST_W(HIST_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .up_valid (up_valid),
  .up_taken (up_taken),
  .lk_hist  (lk_hist),
  .upd_cur  (upd_cur),
  .upd_next (upd_next)
);

// File: tb/ghist_predictor_bench.sv
`timescale 1ns/1ps
module ghist_predictor_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        up_valid;
  logic [31:0] up_pc;
  logic [9:0]  up_hist;
  logic        up_taken;
  logic        lk_taken_x, lk_taken_s;
  logic [9:0]  lk_hist_x, lk_hist_s;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [1:0] m_x [1024];
  logic [1:0] m_s [1024];
  logic [9:0] m_ghr;

  always #2 clk = ~clk;

  ghist_predictor u_ghist_predictor (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken_x), .lk_hist(lk_hist_x),
    .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken));

  ghist_predictor #(.MODE(gpred_pkg::IDX_CONCAT)) u_ghist_predictor_sel (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken_s), .lk_hist(lk_hist_s),
    .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken));

  // R6: bitwise XOR of word address and history
  function automatic int ix_x(input logic [31:0] pc, input logic [9:0] h);
    int r = 0;
    for (int b = 0; b < 10; b++) if (pc[b+2] != h[b]) r += (1 << b);
    return r;
  endfunction

  // R7: two history bits on top of eight address bits
  function automatic int ix_s(input logic [31:0] pc, input logic [9:0] h);
    return (int'(h & 10'd3) * 256) + int'((pc >> 2) & 32'hFF);
  endfunction

  function automatic logic [31:0] pc_for(input int idx, input logic [9:0] h);
    return 32'((idx ^ int'(h)) & 1023) << 2;
  endfunction

  // R3: saturating counter in integer arithmetic
  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    int v = int'(c) + (t ? 1 : -1);
    if (v > 3) v = 3;
    if (v < 0) v = 0;
    return 2'(v);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns later, advance model after rising edge
  task automatic step(input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                      input logic [9:0] uh, input bit ut, input int exp_x, input string tag);
    @(negedge clk);
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_hist = uh; up_taken = ut;
    #1;
    chk({tag, " R2 R6 xor prediction"}, 32'(lk_taken_x), 32'(m_x[ix_x(lpc, m_ghr)][1]));
    chk({tag, " R2 R7 concat prediction"}, 32'(lk_taken_s), 32'(m_s[ix_s(lpc, m_ghr)][1]));
    chk({tag, " R5 history"}, 32'(lk_hist_x), 32'(m_ghr));
    if (exp_x >= 0) chk({tag, " directed"}, 32'(lk_taken_x), 32'(exp_x));
    @(posedge clk);
    if (uv) begin
      m_x[ix_x(upc, uh)] = sat(m_x[ix_x(upc, uh)], ut);
      m_s[ix_s(upc, uh)] = sat(m_s[ix_s(upc, uh)], ut);
      m_ghr = {m_ghr[8:0], ut};
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit          outs [9];
    int          preds [10];
    int          t;
    logic [31:0] a, b;
    bit          uv;
    logic [9:0]  uh;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) begin m_x[i] = 2'b01; m_s[i] = 2'b01; end
    m_ghr = '0;
    rst_n = 1'b0; lk_pc = '0; up_valid = 1'b0; up_pc = '0; up_hist = '0; up_taken = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    step(32'h0, 0, 0, 0, 0, 0, "R1 reset pc0");
    step(32'hFFFF_FFFC, 0, 0, 0, 0, 0, "R1 reset pc_hi");
    step(32'h0000_1234, 0, 0, 0, 0, 0, "R1 reset pc_mid");
    chk("R1 history zero", 32'(lk_hist_x), 32'h0);

    // R3 R4 R9: walk one counter through both saturation points
    t = 10'h155;
    outs  = '{1, 1, 1, 0, 0, 0, 0, 1, 1};
    preds = '{0, 1, 1, 1, 1, 0, 0, 0, 0, 1};
    for (int i = 0; i < 10; i++) begin
      if (i < 9) step(pc_for(t, m_ghr), 1, 32'(t) << 2, 10'h0, outs[i], preds[i], "R3 R4 R9 walk");
      else       step(pc_for(t, m_ghr), 0, 0, 0, 0, preds[i], "R3 R4 walk end");
    end

    // R10: low address bits ignored
    step(pc_for(t, m_ghr) | 32'h3, 0, 0, 0, 0, 1, "R10 low bits");
    // R8: neighbouring counter untouched
    step(pc_for(t ^ 1, m_ghr), 0, 0, 0, 0, 0, "R8 neighbour");

    // R8: supplied history, not live history, picks the counter
    step(32'h0, 1, 32'h0, 10'h2AA, 1, -1, "R8 captured hist a");
    step(32'h0, 1, 32'h0, 10'h2AA, 1, -1, "R8 captured hist b");
    step(pc_for(10'h2AA, m_ghr), 0, 0, 0, 0, 1, "R8 captured index");

    // R9: same-cycle read sees old value
    step(pc_for(10'h0F0, m_ghr), 1, 32'h0F0 << 2, 10'h0, 1, 0, "R9 same cycle");
    step(pc_for(10'h0F0, m_ghr), 0, 0, 0, 0, 1, "R9 next cycle");

    // R7: concatenation index, history low bits 11 after two taken updates
    step(32'h0, 1, 32'h3C << 2, 10'h003, 1, -1, "R7 train a");
    step(32'h0, 1, 32'h3C << 2, 10'h003, 1, -1, "R7 train b");
    @(negedge clk);
    lk_pc = 32'h3C << 2; up_valid = 1'b0;
    #1;
    chk("R7 concat directed", 32'(lk_taken_s), 32'h1);

    // random phase: R2 R3 R5 R6 R7 R8 R10
    for (int n = 0; n < 3000; n++) begin
      a  = $urandom & 32'h0000_0FFF;
      b  = ($urandom % 3 == 0) ? a : ($urandom & 32'h0000_0FFF);
      uv = ($urandom % 4) != 0;
      uh = ($urandom % 5 == 0) ? 10'($urandom) : m_ghr;
      step(b, uv, a, uh, ($urandom % 3) != 0, -1, "random");
    end

    finish_run();
  end

endmodule